// File: doc/BRIEF.md
# Power-On Self-Test Sequencer

This controller runs a fixed chain of built-in tests each time the instrument starts or is asked to test itself. Once the processor reset input is released it starts a run without any request. A later run can be started by a one-cycle pulse on the front-panel test request or on the remote bus test command. Each run first pulses a display-reset line. It then starts four sub-test engines one after another: RAM patterns, ROM placement and checksum, serial I/O loopback, and counter integrity. Between the ROM test and the serial test it switches the measurement gating into the B/A ratio function.

Each sub-test engine is seen only through its handshake. The sequencer raises that engine's start line for one cycle. It then waits for the engine's done line and reads the engine's pass and failure-kind lines on that same cycle. The first failing step ends the run. A step-specific error code is then held for the display, and the pass flag stays low. When every step passes, the pass flag rises and the error code reads zero. The results remain on the outputs until the next run is accepted.

The state machine has thirteen states:
- The three resting states are `ST_IDLE`, `ST_PASS` and `ST_FAIL`. From any of them, a start request moves to `ST_DISP_CLR`.
- `ST_DISP_CLR` moves to `ST_RAM_GO`, and `ST_RAM_GO` moves to `ST_RAM_WAIT`.
- `ST_RAM_WAIT` stays put until done. It then goes to `ST_ROM_GO` on pass, or to `ST_FAIL`.
- `ST_ROM_GO` moves to `ST_ROM_WAIT`. On done, `ST_ROM_WAIT` goes to `ST_SET_RATIO` on pass, or to `ST_FAIL`.
- `ST_SET_RATIO` moves to `ST_SIO_GO`, and `ST_SIO_GO` moves to `ST_SIO_WAIT`. On done, `ST_SIO_WAIT` goes to `ST_CNT_GO` on pass, or to `ST_FAIL`.
- `ST_CNT_GO` moves to `ST_CNT_WAIT`. On done, `ST_CNT_WAIT` goes to `ST_PASS` on pass, or to `ST_FAIL`.

Top module: `post_sequencer`

## Requirements
- R1: After `rst_n` is released, a run begins at the first clock edge without any request, so `disp_reset` is high during the first cycle after release. This automatic start happens once per reset.
- R2: Every run starts with `disp_reset` high for exactly one cycle. No sub-test start may come before that pulse, and the RAM start follows it in the next cycle.
- R3: Each sub-test has one bit of the handshake vectors: bit 0 is RAM, bit 1 is ROM, bit 2 is serial loop, and bit 3 is counter. The start lines fire in the order 0, 1, 2, 3. At most one start line is high in any cycle, and each start is high for a single cycle. A step starts only after the previous step reported done with pass.
- R4: `ratio_mode` goes high after the ROM step passes and before the serial start. It stays high until the next run is accepted. It is low after reset, and it stays low in a run that fails at RAM or ROM.
- R5: The sequencer reads `test_pass` and `test_kind` only in the cycle where the awaited engine's `test_done` is high. A done pulse while no step is waiting has no effect.
- R6: The first failing step stops the run: no later start line fires, and `busy` drops in the next cycle. The error codes are: 1 for RAM; 2 for ROM with kind 0 (placement); 3 for ROM with kind 1 (checksum); 4 for serial loop; 5 for counter with kind 0 (bits not reset); 6 for counter with kind 1 (wrong count). The kind bit is ignored for RAM and serial.
- R7: When all four steps pass, `post_pass` is high and `err_code` is 0.
- R8: A one-cycle pulse on `panel_req` or on `bus_req` starts a new run from idle, pass or fail. Accepting a run clears `post_pass`, `err_code` and `ratio_mode`.
- R9: A request that arrives while `busy` is high is ignored. The run in progress continues unchanged, and no second display pulse follows.
- R10: `busy` is high from the cycle after a run is accepted until the run ends. It is low during reset and in the idle, pass and fail states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low processor reset; a run starts when it is released |
| panel_req | input | 1 | Front-panel test request pulse |
| bus_req | input | 1 | Remote bus test command pulse |
| test_done | input | 4 | Per-engine done (0 RAM, 1 ROM, 2 serial, 3 counter) |
| test_pass | input | 4 | Per-engine pass result, valid with done |
| test_kind | input | 4 | Per-engine failure kind, valid with done |
| test_start | output | 4 | Per-engine one-cycle start |
| disp_reset | output | 1 | One-cycle display-scan reset pulse |
| ratio_mode | output | 1 | Forces the measurement gating into the B/A ratio function |
| busy | output | 1 | Run in progress |
| post_pass | output | 1 | Last run passed |
| err_code | output | ERR_W (4) | Code of the first failing step, 0 if none |

## Verification
A wrong state in this sequencer shows up at the start lines in the very next cycle. Such a state produces a repeated or skipped start, a start that fires before the display pulse, or the serial start firing while `ratio_mode` is still low. An error in the failure mapping or in the cycle when results are read appears once `busy` falls, as a wrong code or a wrong pass flag. To expose reads made on the wrong cycle, the engines drive inverted pass and kind values outside their done cycle. A request that is wrongly accepted while busy appears within one cycle as a second display pulse.

// File: rtl/post_pkg.sv
package post_pkg;

    localparam int NUM_TESTS = 4;
    localparam int IDX_W     = $clog2(NUM_TESTS);

    localparam logic [IDX_W-1:0] IDX_RAM = 2'd0;
    localparam logic [IDX_W-1:0] IDX_ROM = 2'd1;
    localparam logic [IDX_W-1:0] IDX_SIO = 2'd2;
    localparam logic [IDX_W-1:0] IDX_CNT = 2'd3;

    localparam int CODE_NONE      = 0;
    localparam int CODE_RAM       = 1;
    localparam int CODE_ROM_PLACE = 2;
    localparam int CODE_ROM_SUM   = 3;
    localparam int CODE_SIO       = 4;
    localparam int CODE_CNT_RST   = 5;
    localparam int CODE_CNT_COUNT = 6;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DISP_CLR,
        ST_RAM_GO,
        ST_RAM_WAIT,
        ST_ROM_GO,
        ST_ROM_WAIT,
        ST_SET_RATIO,
        ST_SIO_GO,
        ST_SIO_WAIT,
        ST_CNT_GO,
        ST_CNT_WAIT,
        ST_PASS,
        ST_FAIL
    } post_state_t;

endpackage

// File: rtl/post_trigger.sv
// Merges the three ways a run can be requested. The power-on request is
// pending out of reset and is consumed by the first accepted run.
module post_trigger (
    input  logic clk,
    input  logic rst_n,
    input  logic panel_req,
    input  logic bus_req,
    input  logic accept,
    output logic start_req
);

    logic pon_pending_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pon_pending_q <= 1'b1;
        end else if (accept) begin
            pon_pending_q <= 1'b0;
        end
    end

    assign start_req = pon_pending_q | panel_req | bus_req;

    // R1: the automatic request is gone once any run has been accepted
    assert_pon_consumed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !pon_pending_q);

endmodule

// File: rtl/post_errmap.sv
// Maps the failing step and its failure kind to the display error code.
module post_errmap
    import post_pkg::*;
#(
    parameter int ERR_W = 4
) (
    input  logic [IDX_W-1:0] step_idx,
    input  logic             fail_kind,
    output logic [ERR_W-1:0] code
);

    always_comb begin
        unique case (step_idx)
            IDX_RAM: code = ERR_W'(CODE_RAM);
            IDX_ROM: code = fail_kind ? ERR_W'(CODE_ROM_SUM) : ERR_W'(CODE_ROM_PLACE);
            IDX_SIO: code = ERR_W'(CODE_SIO);
            IDX_CNT: code = fail_kind ? ERR_W'(CODE_CNT_COUNT) : ERR_W'(CODE_CNT_RST);
            default: code = ERR_W'(CODE_NONE);
        endcase
    end

    // R6: every step maps to a nonzero code
    always_comb begin
        assert_code_nonzero_R6: assert (code != '0 || $isunknown(step_idx));
    end

endmodule

// File: rtl/post_sequencer.sv
module post_sequencer
    import post_pkg::*;
#(
    parameter int ERR_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 panel_req,
    input  logic                 bus_req,
    input  logic [NUM_TESTS-1:0] test_done,
    input  logic [NUM_TESTS-1:0] test_pass,
    input  logic [NUM_TESTS-1:0] test_kind,
    output logic [NUM_TESTS-1:0] test_start,
    output logic                 disp_reset,
    output logic                 ratio_mode,
    output logic                 busy,
    output logic                 post_pass,
    output logic [ERR_W-1:0]     err_code
);

    post_state_t      st_q, st_nxt;
    logic             start_req;
    logic             accept;
    logic             in_wait;
    logic [IDX_W-1:0] wait_idx;
    logic             step_done;
    logic             step_ok;
    logic             step_fail;
    logic [ERR_W-1:0] map_code;
    logic [ERR_W-1:0] err_q;
    logic             ratio_q;

    post_trigger u_trigger (
        .clk       (clk),
        .rst_n     (rst_n),
        .panel_req (panel_req),
        .bus_req   (bus_req),
        .accept    (accept),
        .start_req (start_req)
    );

    // Which engine the current wait state listens to
    always_comb begin
        in_wait  = 1'b1;
        wait_idx = IDX_RAM;
        unique case (st_q)
            ST_RAM_WAIT: wait_idx = IDX_RAM;
            ST_ROM_WAIT: wait_idx = IDX_ROM;
            ST_SIO_WAIT: wait_idx = IDX_SIO;
            ST_CNT_WAIT: wait_idx = IDX_CNT;
            default:     in_wait  = 1'b0;
        endcase
    end

    assign step_done = in_wait && test_done[wait_idx];
    assign step_ok   = step_done && test_pass[wait_idx];
    assign step_fail = step_done && !test_pass[wait_idx];

    post_errmap #(.ERR_W(ERR_W)) u_errmap (
        .step_idx  (wait_idx),
        .fail_kind (test_kind[wait_idx]),
        .code      (map_code)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_nxt;
        end
    end

    // Next-state logic
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE, ST_PASS, ST_FAIL: begin
                if (start_req) st_nxt = ST_DISP_CLR;
            end
            ST_DISP_CLR:  st_nxt = ST_RAM_GO;
            ST_RAM_GO:    st_nxt = ST_RAM_WAIT;
            ST_RAM_WAIT: begin
                if (step_ok)        st_nxt = ST_ROM_GO;
                else if (step_fail) st_nxt = ST_FAIL;
            end
            ST_ROM_GO:    st_nxt = ST_ROM_WAIT;
            ST_ROM_WAIT: begin
                if (step_ok)        st_nxt = ST_SET_RATIO;
                else if (step_fail) st_nxt = ST_FAIL;
            end
            ST_SET_RATIO: st_nxt = ST_SIO_GO;
            ST_SIO_GO:    st_nxt = ST_SIO_WAIT;
            ST_SIO_WAIT: begin
                if (step_ok)        st_nxt = ST_CNT_GO;
                else if (step_fail) st_nxt = ST_FAIL;
            end
            ST_CNT_GO:    st_nxt = ST_CNT_WAIT;
            ST_CNT_WAIT: begin
                if (step_ok)        st_nxt = ST_PASS;
                else if (step_fail) st_nxt = ST_FAIL;
            end
            default:      st_nxt = ST_IDLE;
        endcase
    end

    // Moore outputs decoded from the state
    always_comb begin
        test_start = '0;
        disp_reset = 1'b0;
        busy       = 1'b1;
        post_pass  = 1'b0;
        unique case (st_q)
            ST_IDLE:     busy = 1'b0;
            ST_FAIL:     busy = 1'b0;
            ST_PASS: begin
                busy      = 1'b0;
                post_pass = 1'b1;
            end
            ST_DISP_CLR: disp_reset          = 1'b1;
            ST_RAM_GO:   test_start[IDX_RAM] = 1'b1;
            ST_ROM_GO:   test_start[IDX_ROM] = 1'b1;
            ST_SIO_GO:   test_start[IDX_SIO] = 1'b1;
            ST_CNT_GO:   test_start[IDX_CNT] = 1'b1;
            default:     ;
        endcase
    end

    assign accept = start_req && !busy;

    // Result and gating registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q   <= '0;
            ratio_q <= 1'b0;
        end else begin
            if (accept) begin
                err_q <= '0;
            end else if (step_fail) begin
                err_q <= map_code;
            end
            if (accept) begin
                ratio_q <= 1'b0;
            end else if (st_q == ST_SET_RATIO) begin
                ratio_q <= 1'b1;
            end
        end
    end

    assign err_code   = err_q;
    assign ratio_mode = ratio_q;

    // R3: one start line at a time, one cycle wide
    assert_start_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(test_start));
    assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|test_start) |=> (test_start == '0));
    // R3: each step follows a passing previous step
    assert_rom_after_ram_R3: assert property (@(posedge clk) disable iff (!rst_n)
        test_start[IDX_ROM] |-> $past(test_done[IDX_RAM] && test_pass[IDX_RAM]));
    assert_sio_after_rom_R3: assert property (@(posedge clk) disable iff (!rst_n)
        test_start[IDX_SIO] |-> $past(test_done[IDX_ROM] && test_pass[IDX_ROM], 2));
    assert_cnt_after_sio_R3: assert property (@(posedge clk) disable iff (!rst_n)
        test_start[IDX_CNT] |-> $past(test_done[IDX_SIO] && test_pass[IDX_SIO]));
    // R2: display pulse is one cycle and leads to the RAM start
    assert_disp_then_ram_R2: assert property (@(posedge clk) disable iff (!rst_n)
        disp_reset |=> (test_start[IDX_RAM] && !disp_reset));
    // R4: gating is in ratio mode whenever the later tests start
    assert_ratio_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (test_start[IDX_SIO] || test_start[IDX_CNT]) |-> ratio_mode);
    // R7: a pass carries no error code
    assert_pass_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        post_pass |-> (err_code == '0));
    // R6: a run that ends without passing holds a code
    assert_fail_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !post_pass) |-> (err_code != '0));
    // R9: a request while busy never restarts the display pulse
    assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (panel_req || bus_req)) |=> !disp_reset);

endmodule

// File: tb/post_sequencer_test.sv
module post_sequencer_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       panel_req;
    logic       bus_req;
    logic [3:0] test_done;
    logic [3:0] test_pass;
    logic [3:0] test_kind;
    logic [3:0] test_start;
    logic       disp_reset;
    logic       ratio_mode;
    logic       busy;
    logic       post_pass;
    logic [3:0] err_code;

    always #5 clk = ~clk;

    post_sequencer uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .panel_req  (panel_req),
        .bus_req    (bus_req),
        .test_done  (test_done),
        .test_pass  (test_pass),
        .test_kind  (test_kind),
        .test_start (test_start),
        .disp_reset (disp_reset),
        .ratio_mode (ratio_mode),
        .busy       (busy),
        .post_pass  (post_pass),
        .err_code   (err_code)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    bit cfg_pass [4];
    bit cfg_kind [4];
    int cfg_lat  [4];
    bit spur_on = 0;

    int order_log [16];
    int order_n;
    int disp_n;
    int disp_at_first;
    int ratio_err;
    int width_err;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_log();
        order_n       = 0;
        disp_n        = 0;
        disp_at_first = -1;
        ratio_err     = 0;
        width_err     = 0;
    endtask

    function automatic int step_code(input int i, input bit kind);
        case (i)
            0:       return 1;
            1:       return kind ? 3 : 2;
            2:       return 4;
            default: return kind ? 6 : 5;
        endcase
    endfunction

    function automatic int exp_code();
        for (int i = 0; i < 4; i++) begin
            if (!cfg_pass[i]) return step_code(i, cfg_kind[i]);
        end
        return 0;
    endfunction

    function automatic int exp_steps();
        for (int i = 0; i < 4; i++) begin
            if (!cfg_pass[i]) return i + 1;
        end
        return 4;
    endfunction

    // Sub-test engine models: results are inverted outside the done cycle
    initial begin : engines
        bit act [4];
        int cd  [4];
        logic [3:0] prev_start;
        prev_start = '0;
        for (int i = 0; i < 4; i++) begin
            act[i] = 0;
            cd[i]  = 0;
        end
        test_done = '0;
        test_pass = '0;
        test_kind = '0;
        forever begin
            @(negedge clk);
            test_done = '0;
            if (disp_reset) disp_n++;
            if (test_start != '0 && test_start == prev_start) width_err++;
            if ((test_start[2] || test_start[3]) && !ratio_mode) ratio_err++;
            for (int i = 0; i < 4; i++) begin
                if (!rst_n) begin
                    act[i] = 0;
                end else if (test_start[i]) begin
                    if (order_n == 0) disp_at_first = disp_n;
                    if (order_n < 16) order_log[order_n] = i;
                    order_n++;
                    act[i] = 1;
                    cd[i]  = cfg_lat[i];
                end else if (act[i]) begin
                    cd[i]--;
                    if (cd[i] <= 0) begin
                        test_done[i] = 1'b1;
                        act[i]       = 0;
                    end
                end
            end
            for (int i = 0; i < 4; i++) begin
                test_pass[i] = test_done[i] ? cfg_pass[i] : !cfg_pass[i];
                test_kind[i] = test_done[i] ? cfg_kind[i] : !cfg_kind[i];
            end
            if (spur_on) begin
                test_done[0] = 1'b1;
                test_pass[0] = 1'b0;
            end
            prev_start = test_start;
        end
    end

    task automatic wait_end(input int poke, input bit poke_bus);
        int cyc = 0;
        while (busy && cyc < 3000) begin
            if (cyc == poke) begin
                if (poke_bus) bus_req = 1'b1;
                else          panel_req = 1'b1;
            end
            @(negedge clk);
            panel_req = 1'b0;
            bus_req   = 1'b0;
            cyc++;
        end
        if (busy) check(0, "watchdog run end R10", 1, 0);
    endtask

    task automatic check_run(input string tag);
        int n = exp_steps();
        int ec = exp_code();
        bit order_ok = (order_n == n);
        for (int i = 0; i < n && i < 16; i++) begin
            if (order_log[i] != i) order_ok = 0;
        end
        check(order_ok, {"R3 R6 order ", tag}, order_n, n);
        check(width_err == 0, {"R3 start width ", tag}, width_err, 0);
        check(disp_n == 1 && disp_at_first == 1, {"R2 display pulse ", tag}, disp_n, 1);
        check(ratio_err == 0, {"R4 ratio before serial ", tag}, ratio_err, 0);
        check(ratio_mode == (cfg_pass[0] && cfg_pass[1]), {"R4 ratio level ", tag},
              ratio_mode, cfg_pass[0] && cfg_pass[1]);
        check(int'(err_code) == ec, {"R5 R6 error code ", tag}, err_code, ec);
        check(post_pass == (ec == 0), {"R7 pass flag ", tag}, post_pass, ec == 0);
    endtask

    task automatic run_test(input bit use_bus, input int poke, input string tag);
        clear_log();
        if (use_bus) bus_req = 1'b1;
        else         panel_req = 1'b1;
        @(negedge clk);
        panel_req = 1'b0;
        bus_req   = 1'b0;
        check(busy == 1'b1, {"R8 R10 busy after request ", tag}, busy, 1);
        wait_end(poke, !use_bus);
        check_run(tag);
        repeat (4) @(negedge clk);
        check(busy == 1'b0 && disp_n == 1, {"R9 no restart ", tag}, disp_n, 1);
    endtask

    task automatic set_all(input bit p, input int lat);
        for (int i = 0; i < 4; i++) begin
            cfg_pass[i] = p;
            cfg_kind[i] = 0;
            cfg_lat[i]  = lat;
        end
    endtask

    initial begin : watchdog
        #2_000_000;
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog R10: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd7319);
        rst_n     = 1'b0;
        panel_req = 1'b0;
        bus_req   = 1'b0;
        set_all(1, 2);
        clear_log();
        repeat (5) @(negedge clk);
        // Reset state
        check(busy == 0, "R10 busy in reset", busy, 0);
        check(post_pass == 0 && err_code == 0, "R7 results in reset", err_code, 0);
        check(ratio_mode == 0, "R4 ratio in reset", ratio_mode, 0);
        check(test_start == 0 && disp_reset == 0, "R3 starts in reset", test_start, 0);

        // Power-on run with no request
        clear_log();
        rst_n = 1'b1;
        @(negedge clk);
        check(disp_reset == 1, "R1 automatic start", disp_reset, 1);
        wait_end(-1, 0);
        check_run("power-on");
        repeat (6) @(negedge clk);
        check(busy == 0 && disp_n == 1, "R1 single automatic run", disp_n, 1);

        // Directed: each failure code, alternating triggers
        for (int f = 0; f < 6; f++) begin
            set_all(1, 1 + f % 3);
            case (f)
                0: cfg_pass[0] = 0;
                1: begin cfg_pass[1] = 0; cfg_kind[1] = 0; end
                2: begin cfg_pass[1] = 0; cfg_kind[1] = 1; end
                3: begin cfg_pass[2] = 0; cfg_kind[2] = 1; end
                4: begin cfg_pass[3] = 0; cfg_kind[3] = 0; end
                default: begin cfg_pass[3] = 0; cfg_kind[3] = 1; end
            endcase
            run_test(f[0], 3, $sformatf("directed code %0d", f + 1));
        end

        // R5: a done pulse while idle changes nothing
        spur_on = 1;
        @(negedge clk);
        spur_on = 0;
        repeat (2) @(negedge clk);
        check(busy == 0 && int'(err_code) == 6, "R5 stray done ignored", err_code, 6);

        // R8: restart from the pass state
        set_all(1, 1);
        run_test(0, -1, "pass back-to-back a");
        run_test(1, 0, "pass back-to-back b");

        // Constrained random runs
        for (int r = 0; r < 40; r++) begin
            for (int i = 0; i < 4; i++) begin
                cfg_pass[i] = ($urandom % 8) != 0;
                cfg_kind[i] = $urandom % 2;
                cfg_lat[i]  = 1 + $urandom % 6;
            end
            run_test($urandom % 2, $urandom % 12, $sformatf("random %0d", r));
        end

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule